// File: doc/BRIEF.md
# Master-Aware Control and Status Register Bank

This block is a small set of 8-bit control and status registers that sits behind an AHB-Lite-style slave port. Each location has its own access rule: plain read-write control storage, a fixed read-only identification value, a bank of sticky status bits that hardware events set and software clears by writing ones, and one location whose rule depends on which bus master issues the transfer. For a host master that location can only be read. For a test master it can be read and written.

The bus side captures address and control in the address phase. It applies write data in the data phase that follows. Read data is returned in that same data phase. The slave never inserts wait states and always answers OKAY. The register contents are driven out continuously to the logic around the block, and bit 0 of the control register drives a dedicated force-off line.

Map (byte offsets): control 0x00, status 0x04, identification 0x08, master-dependent 0x14. Every other offset is unmapped. The default host master ID is 0 and the default test master ID is 2.

Top module: `regbank_top`

## Requirements
- R1: After reset the registers read back as follows: control 0x0C, status 0x00, identification 0x5A, master-dependent 0x00. `force_off_o` is 0 after reset.
- R2: The control register (0x00) reads back the last value written to it. `ctrl_o` carries that value and `force_off_o` equals its bit 0.
- R3: A write to the identification register (0x08) has no effect; it keeps reading 0x5A.
- R4: The master-dependent register (0x14) takes writes only when `hmaster` equals the test ID (2). When `hmaster` equals the host ID (0), writes leave both its read value and `dual_o` unchanged.
- R5: Any `hmaster` value other than the host or test ID (for example 5) is treated as the host, so its writes to 0x14 are ignored.
- R6: A 1 on bit n of `evt_i` in a cycle sets status bit n. The bit stays set until software clears it, and events need no bus activity.
- R7: A write to the status register (0x04) clears every bit where the written data is 1 and leaves every bit where the data is 0.
- R8: If an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R9: A read of an unmapped offset returns 0x00. A write to one changes no register.
- R10: `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R11: A transfer counts only when `hsel` is 1, `hready` is 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) transfers, and transfers with `hsel` low, change nothing.
- R12: A write followed in the next cycle by a read of the same register returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| haddr | input | 8 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hready | input | 1 | Bus ready, the previous transfer is complete |
| hwdata | input | 8 | Write data, valid in the data phase |
| hmaster | input | 4 | ID of the master that issues the transfer |
| evt_i | input | 8 | Event pulses that set the status bits |
| hrdata | output | 8 | Read data, valid in the data phase |
| hreadyout | output | 1 | Transfer done, always 1 |
| hresp | output | 1 | Response, always 0 (OKAY) |
| force_off_o | output | 1 | Bit 0 of the control register |
| ctrl_o | output | 8 | Control register contents |
| status_o | output | 8 | Status register contents |
| dual_o | output | 8 | Master-dependent register contents |

## Verification
Two functions can act on a status bit in the same cycle: a hardware event that sets it and a bus write that clears it. The bench provokes this by driving `evt_i` in the data phase of a clearing write. The event covers only part of the mask. On the read that follows, the bits with an event must stay set and the other masked bits must clear. A second overlap is a read issued in the data phase of a write to the same register. That read must return the new value, which shows the write lands before the read data is formed.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 8;
    localparam int MID_W  = 4;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

endpackage

// File: rtl/regbank_ahb_front.sv
module regbank_ahb_front #(
    parameter int ADDR_W = regbank_pkg::ADDR_W,
    parameter int MID_W  = regbank_pkg::MID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hready,
    input  logic [MID_W-1:0]  hmaster,
    output logic              ph_valid,
    output logic              ph_write,
    output logic [ADDR_W-1:0] ph_addr,
    output logic [MID_W-1:0]  ph_master
);

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [MID_W-1:0]  master;
    } phase_t;

    phase_t ph_d, ph_q;
    logic   active_tr;

    always_comb begin
        active_tr = (htrans == regbank_pkg::TR_NONSEQ) || (htrans == regbank_pkg::TR_SEQ);
        ph_d = ph_q;
        if (hready) begin
            ph_d.valid  = hsel && active_tr;
            ph_d.write  = hwrite;
            ph_d.addr   = haddr;
            ph_d.master = hmaster;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign ph_valid  = ph_q.valid;
    assign ph_write  = ph_q.write;
    assign ph_addr   = ph_q.addr;
    assign ph_master = ph_q.master;

    AST_IDLE_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (!hsel || !htrans[1])) |=> !ph_valid); // R11

endmodule

// File: rtl/regbank_rw.sv
module regbank_rw #(
    parameter int          WIDTH = regbank_pkg::REG_W,
    parameter logic [7:0]  RESET = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= WIDTH'(RESET);
        else        val_q <= val_d;
    end

    assign q = val_q;

    AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R2

endmodule

// File: rtl/regbank_w1c.sv
module regbank_w1c #(
    parameter int WIDTH = regbank_pkg::REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    input  logic [WIDTH-1:0] set_i,
    output logic [WIDTH-1:0] stat_o
);

    logic [WIDTH-1:0] st_d, st_q;
    logic [WIDTH-1:0] eff_clr;

    always_comb begin
        eff_clr = clr_en ? clr_mask : '0;
        // the set term is applied after the clear so an event is never lost
        st_d = (st_q & ~eff_clr) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R8

    AST_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((stat_o & $past(clr_mask) & ~$past(set_i)) == '0)); // R7

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~({WIDTH{clr_en}} & clr_mask)))
                  == $past(stat_o & ~({WIDTH{clr_en}} & clr_mask)))); // R6

endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
    parameter int         ADDR_W    = regbank_pkg::ADDR_W,
    parameter int         DATA_W    = regbank_pkg::REG_W,
    parameter int         MID_W     = regbank_pkg::MID_W,
    parameter int         OFF_CTRL  = 'h00,
    parameter int         OFF_STAT  = 'h04,
    parameter int         OFF_INFO  = 'h08,
    parameter int         OFF_DUAL  = 'h14,
    parameter logic [7:0] CTRL_RST  = 8'h0C,
    parameter logic [7:0] DUAL_RST  = 8'h00,
    parameter logic [7:0] INFO_VAL  = 8'h5A,
    parameter int         HOST_ID   = 0,
    parameter int         TEST_ID   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hready,
    input  logic [DATA_W-1:0] hwdata,
    input  logic [MID_W-1:0]  hmaster,
    input  logic [DATA_W-1:0] evt_i,
    output logic [DATA_W-1:0] hrdata,
    output logic              hreadyout,
    output logic              hresp,
    output logic              force_off_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] dual_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_INFO = ADDR_W'(OFF_INFO);
    localparam logic [ADDR_W-1:0] A_DUAL = ADDR_W'(OFF_DUAL);
    localparam logic [MID_W-1:0]  M_TEST = MID_W'(TEST_ID);
    localparam logic [MID_W-1:0]  M_HOST = MID_W'(HOST_ID);

    logic              ph_valid, ph_write;
    logic [ADDR_W-1:0] ph_addr;
    logic [MID_W-1:0]  ph_master;
    logic              wr_act, rd_act, is_test;
    logic              ctrl_we, stat_we, dual_we;
    logic [DATA_W-1:0] rdata_c;

    regbank_ahb_front #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsel      (hsel),
        .haddr     (haddr),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hready    (hready),
        .hmaster   (hmaster),
        .ph_valid  (ph_valid),
        .ph_write  (ph_write),
        .ph_addr   (ph_addr),
        .ph_master (ph_master)
    );

    // decode of the captured data-phase transfer
    always_comb begin
        wr_act  = ph_valid && ph_write;
        rd_act  = ph_valid && !ph_write;
        // unknown IDs fall back to host rules; only the test ID unlocks writes
        is_test = (ph_master == M_TEST) && (ph_master != M_HOST);
        ctrl_we = wr_act && (ph_addr == A_CTRL);
        stat_we = wr_act && (ph_addr == A_STAT);
        dual_we = wr_act && (ph_addr == A_DUAL) && is_test;
    end

    regbank_rw #(.WIDTH(DATA_W), .RESET(CTRL_RST)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctrl_we),
        .wdata (hwdata),
        .q     (ctrl_o)
    );

    regbank_rw #(.WIDTH(DATA_W), .RESET(DUAL_RST)) u_dual (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dual_we),
        .wdata (hwdata),
        .q     (dual_o)
    );

    regbank_w1c #(.WIDTH(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (stat_we),
        .clr_mask (hwdata),
        .set_i    (evt_i),
        .stat_o   (status_o)
    );

    always_comb begin
        rdata_c = '0;
        if (rd_act) begin
            case (ph_addr)
                A_CTRL:  rdata_c = ctrl_o;
                A_STAT:  rdata_c = status_o;
                A_INFO:  rdata_c = DATA_W'(INFO_VAL);
                A_DUAL:  rdata_c = dual_o;
                default: rdata_c = '0;
            endcase
        end
    end

    assign hrdata      = rdata_c;
    assign hreadyout   = 1'b1;
    assign hresp       = 1'b0;
    assign force_off_o = ctrl_o[0];

    AST_CTRL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_valid && ph_write && ph_addr == A_CTRL) |=> (ctrl_o == $past(hwdata))); // R2

    AST_DUAL_HOST_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_valid && ph_write && ph_addr == A_DUAL && ph_master != M_TEST) |=> $stable(dual_o)); // R4

    AST_DUAL_TEST_RW: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_valid && ph_write && ph_addr == A_DUAL && ph_master == M_TEST) |=> (dual_o == $past(hwdata))); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_valid && !ph_write && ph_addr != A_CTRL && ph_addr != A_STAT
         && ph_addr != A_INFO && ph_addr != A_DUAL) |-> (hrdata == '0)); // R9

    AST_NO_SIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_valid && ph_write) |=> ($stable(ctrl_o) && $stable(dual_o))); // R11

endmodule

// File: tb/test_regbank_top.sv
module test_regbank_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsel = 1'b0;
    logic [7:0] haddr = '0;
    logic [1:0] htrans = 2'b00;
    logic       hwrite = 1'b0;
    logic       hready = 1'b1;
    logic [7:0] hwdata = '0;
    logic [3:0] hmaster = '0;
    logic [7:0] evt_i = '0;
    logic [7:0] hrdata;
    logic       hreadyout, hresp, force_off_o;
    logic [7:0] ctrl_o, status_o, dual_o;

    int checks = 0;
    int failures = 0;

    localparam logic [3:0] HOST = 4'd0;
    localparam logic [3:0] TEST = 4'd2;
    localparam logic [3:0] OTHER = 4'd5;

    always #2 clk = ~clk;

    regbank_top i_regbank_top (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hmaster(hmaster),
        .evt_i(evt_i), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
        .force_off_o(force_off_o), .ctrl_o(ctrl_o), .status_o(status_o), .dual_o(dual_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [3:0] m,
                      input logic [7:0] ev = 8'h00, input logic sel = 1'b1,
                      input logic [1:0] tr = 2'b10);
        hsel = sel; haddr = a; htrans = tr; hwrite = 1'b1; hmaster = m;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = d; evt_i = ev;
        @(posedge clk); @(negedge clk);
        evt_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] m, input string tag,
                      input logic [7:0] exp);
        hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = 1'b0; hmaster = m;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        chk(tag, hrdata, exp);
        chk("R10 hreadyout", {7'd0, hreadyout}, 8'h01);
        chk("R10 hresp", {7'd0, hresp}, 8'h00);
    endtask

    task automatic pulse(input logic [7:0] ev);
        evt_i = ev;
        @(posedge clk); @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset();
        rd(8'h00, HOST, "R1 ctrl reset", 8'h0C);
        rd(8'h04, HOST, "R1 status reset", 8'h00);
        rd(8'h08, HOST, "R1 info reset", 8'h5A);
        rd(8'h14, HOST, "R1 dual reset", 8'h00);
        chk("R1 force_off reset", {7'd0, force_off_o}, 8'h00);
    endtask

    task automatic t_ctrl();
        wr(8'h00, 8'h5B, HOST);
        rd(8'h00, HOST, "R2 ctrl readback", 8'h5B);
        chk("R2 ctrl_o", ctrl_o, 8'h5B);
        chk("R2 force_off set", {7'd0, force_off_o}, 8'h01);
        wr(8'h00, 8'hA4, TEST);
        rd(8'h00, HOST, "R2 ctrl readback 2", 8'hA4);
        chk("R2 force_off clear", {7'd0, force_off_o}, 8'h00);
    endtask

    task automatic t_info();
        wr(8'h08, 8'hFF, TEST);
        rd(8'h08, HOST, "R3 info after write", 8'h5A);
    endtask

    task automatic t_dual();
        wr(8'h14, 8'h33, HOST);
        rd(8'h14, HOST, "R4 host write ignored", 8'h00);
        wr(8'h14, 8'h6E, TEST);
        rd(8'h14, TEST, "R4 test write taken", 8'h6E);
        chk("R4 dual_o", dual_o, 8'h6E);
        wr(8'h14, 8'h11, HOST);
        rd(8'h14, HOST, "R4 host write ignored 2", 8'h6E);
        wr(8'h14, 8'h22, OTHER);
        rd(8'h14, HOST, "R5 other id ignored", 8'h6E);
        chk("R5 dual_o", dual_o, 8'h6E);
    endtask

    task automatic t_w1c();
        pulse(8'h05);
        pulse(8'h40);
        repeat (3) @(negedge clk);
        chk("R6 status_o sticky", status_o, 8'h45);
        rd(8'h04, HOST, "R6 status read", 8'h45);
        wr(8'h04, 8'h00, HOST);
        rd(8'h04, HOST, "R7 zero keeps", 8'h45);
        wr(8'h04, 8'h04, HOST);
        rd(8'h04, HOST, "R7 one clears", 8'h41);
        wr(8'h04, 8'hFF, HOST);
        rd(8'h04, HOST, "R7 clear all", 8'h00);
    endtask

    task automatic t_collide();
        pulse(8'h03);
        rd(8'h04, HOST, "R8 pre", 8'h03);
        wr(8'h04, 8'h03, HOST, 8'h01);
        rd(8'h04, HOST, "R8 event beats clear", 8'h01);
        wr(8'h04, 8'h01, HOST);
        rd(8'h04, HOST, "R8 cleanup", 8'h00);
    endtask

    task automatic t_unmapped();
        rd(8'h10, HOST, "R9 unmapped read", 8'h00);
        rd(8'h7F, TEST, "R9 unmapped read 2", 8'h00);
        wr(8'h10, 8'hFF, TEST);
        wr(8'h01, 8'hFF, TEST);
        rd(8'h00, HOST, "R9 ctrl untouched", 8'hA4);
        rd(8'h14, HOST, "R9 dual untouched", 8'h6E);
        rd(8'h04, HOST, "R9 status untouched", 8'h00);
    endtask

    task automatic t_idle();
        wr(8'h00, 8'h77, TEST, 8'h00, 1'b1, 2'b00);
        rd(8'h00, HOST, "R11 idle ignored", 8'hA4);
        wr(8'h00, 8'h77, TEST, 8'h00, 1'b1, 2'b01);
        rd(8'h00, HOST, "R11 busy ignored", 8'hA4);
        wr(8'h14, 8'h77, TEST, 8'h00, 1'b0, 2'b10);
        rd(8'h14, HOST, "R11 hsel low ignored", 8'h6E);
        wr(8'h00, 8'h3C, TEST, 8'h00, 1'b1, 2'b11);
        rd(8'h00, HOST, "R11 seq taken", 8'h3C);
    endtask

    task automatic t_b2b();
        hsel = 1'b1; haddr = 8'h00; htrans = 2'b10; hwrite = 1'b1; hmaster = HOST;
        @(posedge clk); @(negedge clk);
        hwdata = 8'h96; hwrite = 1'b0;
        @(posedge clk); @(negedge clk);
        hsel = 1'b0; htrans = 2'b00;
        chk("R12 read after write", hrdata, 8'h96);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_info();
        t_dual();
        t_w1c();
        t_collide();
        t_unmapped();
        t_idle();
        t_b2b();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule